// File: doc/BRIEF.md
# Paged Memory Window Controller for an 8-bit CPU

This block sits between an 8-bit CPU bus with a 16-bit address and one ROM and one SRAM device. It divides the 64K logical address space into two halves. The upper 32K always reaches a fixed SRAM page. The lower 32K is a window that shows either a chosen ROM page or a chosen SRAM page. Two write-only configuration registers sit in the CPU's I/O space and select what the window shows. One register holds the ROM page and a ROM switch-out flag. The other holds the SRAM page. Each register drives only the extra high address lines of its own device.

For each memory cycle the block drives the active-low ROM and SRAM chip enables and the high address lines (A15 upward) of each device. The CPU's own A0 to A14 go straight to both devices. Both registers clear on reset, so the CPU starts from ROM page 0 and finds SRAM in the upper half. When the CPU addresses the upper half, the SRAM high lines are forced to the top page whatever the SRAM register holds. Code that rewrites the map therefore always keeps a stable RAM context.

Top module: `bank_switch_ctrl`

## Requirements
- R1: Synchronous active-high reset clears both configuration registers to 0x00, so rom_hi reads 0 and the lower window shows ROM.
- R2: After reset, a memory request below 0x8000 asserts rom_ce_n with rom_hi = 0, and a request at 0x8000 or above asserts ram_ce_n.
- R3: An I/O write to port 0x7C loads the ROM register at the clock edge. Data bits 4..0 then drive rom_hi[4:0] (bit 0 is device A15, bit 4 is A19), giving 32 pages.
- R4: An I/O write to port 0x78 loads the SRAM register. Data bits 3..0 drive ram_hi[3:0] (bit 0 is device A15) whenever cpu_addr[15] is 0, giving 16 pages.
- R5: While bit 7 of the ROM register is 1, a lower-window memory request asserts ram_ce_n and never rom_ce_n, using the SRAM register's page. While bit 7 is 0, such a request asserts rom_ce_n.
- R6: Whenever cpu_addr[15] is 1, ram_hi is 4'b1111, and a memory request asserts ram_ce_n, whatever either register holds.
- R7: The port decode compares all of cpu_addr[7:0] and ignores cpu_addr[15:8]. A write to any other low byte (for example 0x79, 0x7D, 0xFC) changes neither register.
- R8: A register loads only when iorq_n and wr_n are both 0 and m1_n is 1. An I/O read, an interrupt-acknowledge cycle (iorq_n and m1_n both 0) and a memory write to a port-like address all leave both registers unchanged.
- R9: During a memory request (mreq_n 0 with rd_n or wr_n 0), exactly one of rom_ce_n and ram_ce_n is 0. With no memory request, both are 1.
- R10: An SRAM register page of 15, with ROM switched out, makes the lower window alias the fixed upper page (ram_hi = 4'b1111 for both halves).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus (write data) |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| ram_ce_n | output | 1 | SRAM chip enable, active low |
| rom_hi | output | 5 | ROM device address lines A15..A19 |
| ram_hi | output | 4 | SRAM device address lines A15..A18 |

## Verification
The chip enables and both high-address buses are combinational from the current bus inputs and the stored registers. They are due in the same cycle as the request, so the bench drives each request at a falling edge and samples 2 ns later, before the next rising edge. A register write takes effect at the first rising edge that sees the qualified I/O write. The bench therefore issues each write for one full cycle and probes in a later cycle. The sweeps cover every ROM page, every SRAM page with ROM switched out, and the ignored-write cases, with expected values computed from the written data.

// File: rtl/bank_switch_pkg.sv
package bank_switch_pkg;

    localparam int CPU_AW       = 16;
    localparam int CPU_DW       = 8;
    localparam int ROM_PG_W     = 5;
    localparam int RAM_PG_W     = 4;
    localparam int ROM_OFF_BIT  = 7;
    localparam logic [7:0] ROM_CFG_PORT = 8'h7C;
    localparam logic [7:0] RAM_CFG_PORT = 8'h78;

    // Decoded bus cycle, active-high view of the strobes.
    typedef struct packed {
        logic mem_req;
        logic io_wr;
        logic upper;
        logic [7:0] port;
    } bus_cycle_t;

    // Where the current memory cycle lands.
    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_ROM  = 2'd1,
        TGT_RAM  = 2'd2
    } mem_target_t;

    function automatic bus_cycle_t decode_cycle(
        input logic [CPU_AW-1:0] addr,
        input logic mreq_n, input logic iorq_n,
        input logic rd_n, input logic wr_n, input logic m1_n);
        bus_cycle_t c;
        c.mem_req = !mreq_n && (!rd_n || !wr_n);
        c.io_wr   = !iorq_n && !wr_n && m1_n;
        c.upper   = addr[CPU_AW-1];
        c.port    = addr[7:0];
        return c;
    endfunction

endpackage

// File: rtl/bank_port_decode.sv
module bank_port_decode
    import bank_switch_pkg::*;
#(
    parameter logic [7:0] ROM_PORT = ROM_CFG_PORT,
    parameter logic [7:0] RAM_PORT = RAM_CFG_PORT
) (
    input  bus_cycle_t cyc,
    output logic       rom_ld,
    output logic       ram_ld
);
    always_comb begin
        rom_ld = cyc.io_wr && (cyc.port == ROM_PORT);
        ram_ld = cyc.io_wr && (cyc.port == RAM_PORT);
    end
endmodule

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= d;
    end
endmodule

// File: rtl/bank_window_map.sv
module bank_window_map
    import bank_switch_pkg::*;
#(
    parameter int ROM_W   = ROM_PG_W,
    parameter int RAM_W   = RAM_PG_W,
    parameter int OFF_BIT = ROM_OFF_BIT
) (
    input  bus_cycle_t        cyc,
    input  logic [CPU_DW-1:0] rom_cfg,
    input  logic [CPU_DW-1:0] ram_cfg,
    output mem_target_t       tgt,
    output logic [ROM_W-1:0]  rom_hi,
    output logic [RAM_W-1:0]  ram_hi
);
    logic rom_off;

    always_comb begin
        rom_off = rom_cfg[OFF_BIT];
        rom_hi  = rom_cfg[ROM_W-1:0];
        if (!cyc.mem_req)
            tgt = TGT_NONE;
        else if (cyc.upper || rom_off)
            tgt = TGT_RAM;
        else
            tgt = TGT_ROM;
    end

    // Each SRAM page line is pulled high while the upper half is addressed.
    for (genvar i = 0; i < RAM_W; i++) begin : g_ram_line
        assign ram_hi[i] = ram_cfg[i] | cyc.upper;
    end
endmodule

// File: rtl/bank_switch_ctrl.sv
module bank_switch_ctrl
    import bank_switch_pkg::*;
#(
    parameter logic [7:0] ROM_PORT = ROM_CFG_PORT,
    parameter logic [7:0] RAM_PORT = RAM_CFG_PORT,
    parameter int         ROM_W    = ROM_PG_W,
    parameter int         RAM_W    = RAM_PG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [CPU_DW-1:0] cpu_data,
    input  logic              mreq_n,
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              m1_n,
    output logic              rom_ce_n,
    output logic              ram_ce_n,
    output logic [ROM_W-1:0]  rom_hi,
    output logic [RAM_W-1:0]  ram_hi
);
    bus_cycle_t        cyc;
    logic              rom_ld, ram_ld;
    logic [CPU_DW-1:0] rom_cfg, ram_cfg;
    mem_target_t       tgt;

    assign cyc = decode_cycle(cpu_addr, mreq_n, iorq_n, rd_n, wr_n, m1_n);

    bank_port_decode #(.ROM_PORT(ROM_PORT), .RAM_PORT(RAM_PORT)) u_dec (
        .cyc(cyc), .rom_ld(rom_ld), .ram_ld(ram_ld)
    );

    bank_cfg_reg #(.W(CPU_DW)) u_rom_reg (
        .clk(clk), .rst(rst), .ld(rom_ld), .d(cpu_data), .q(rom_cfg)
    );

    bank_cfg_reg #(.W(CPU_DW)) u_ram_reg (
        .clk(clk), .rst(rst), .ld(ram_ld), .d(cpu_data), .q(ram_cfg)
    );

    bank_window_map #(.ROM_W(ROM_W), .RAM_W(RAM_W)) u_map (
        .cyc(cyc), .rom_cfg(rom_cfg), .ram_cfg(ram_cfg),
        .tgt(tgt), .rom_hi(rom_hi), .ram_hi(ram_hi)
    );

    assign rom_ce_n = (tgt != TGT_ROM);
    assign ram_ce_n = (tgt != TGT_RAM);
endmodule

// File: rtl/bank_switch_chk.sv
module bank_switch_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_data,
    input logic        mreq_n,
    input logic        iorq_n,
    input logic        rd_n,
    input logic        wr_n,
    input logic        m1_n,
    input logic        rom_ce_n,
    input logic        ram_ce_n,
    input logic [4:0]  rom_hi,
    input logic [3:0]  ram_hi
);
    logic wr_rom_port, wr_ram_port, mem_cycle;
    assign wr_rom_port = !iorq_n && !wr_n && m1_n && cpu_addr[7:0] == 8'h7C;
    assign wr_ram_port = !iorq_n && !wr_n && m1_n && cpu_addr[7:0] == 8'h78;
    assign mem_cycle   = !mreq_n && (!rd_n || !wr_n);

    AST_ONE_ENABLE: assert property (@(posedge clk) disable iff (rst)
        mem_cycle |-> $countones({!rom_ce_n, !ram_ce_n}) == 1); // R9
    AST_IDLE_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !mem_cycle |-> (rom_ce_n && ram_ce_n)); // R9
    AST_UPPER_TOP_PAGE: assert property (@(posedge clk) disable iff (rst)
        cpu_addr[15] |-> (ram_hi == 4'hF && (!mem_cycle || !ram_ce_n))); // R6
    AST_ROM_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_rom_port |=> rom_hi == $past(cpu_data[4:0])); // R3
    AST_RAM_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_ram_port |=> (cpu_addr[15] || ram_hi == $past(cpu_data[3:0]))); // R4
    AST_ROM_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_rom_port |=> $stable(rom_hi)); // R8
endmodule

bind bank_switch_ctrl bank_switch_chk u_chk (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
    .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .rom_hi(rom_hi), .ram_hi(ram_hi)
);

// File: tb/tb_bank_switch_ctrl.sv
module tb_bank_switch_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
    logic        rom_ce_n, ram_ce_n;
    logic [4:0]  rom_hi;
    logic [3:0]  ram_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bank_switch_ctrl dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n),
        .rom_ce_n(rom_ce_n), .ram_ce_n(ram_ce_n), .rom_hi(rom_hi), .ram_hi(ram_hi)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
    endtask

    // One-cycle I/O or memory write with chosen strobes.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input bit io, input bit m1);
        @(negedge clk);
        cpu_addr = a; cpu_data = d;
        iorq_n = !io; mreq_n = io; wr_n = 1'b0; rd_n = 1'b1; m1_n = !m1;
        @(negedge clk);
        idle();
    endtask

    task automatic io_read(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a; iorq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1; mreq_n = 1'b1; m1_n = 1'b1;
        @(negedge clk);
        idle();
    endtask

    // Drive a memory access and sample the outputs 2 ns later.
    task automatic probe(input logic [15:0] a, input bit wr,
                         output logic rce, output logic ace,
                         output logic [4:0] rh, output logic [3:0] ah);
        @(negedge clk);
        cpu_addr = a; mreq_n = 1'b0; iorq_n = 1'b1; m1_n = 1'b1;
        rd_n = wr; wr_n = !wr;
        #2;
        rce = rom_ce_n; ace = ram_ce_n; rh = rom_hi; ah = ram_hi;
    endtask

    // Expected lower/upper mapping from the programmed register values.
    task automatic check_map(input logic [7:0] romv, input logic [7:0] ramv, input string req);
        logic rce, ace;
        logic [4:0] rh;
        logic [3:0] ah;
        bit off;
        off = romv[7];
        probe(16'h1234, 1'b0, rce, ace, rh, ah);
        check(rh == romv[4:0], req, rh, romv[4:0]);
        check(rce == off && ace == !off, req, {rce, ace}, {off, !off});
        if (off) check(ah == ramv[3:0], req, ah, ramv[3:0]);
        probe(16'hC321, 1'b1, rce, ace, rh, ah);
        check(rce && !ace && ah == 4'hF, {req, "/R6"}, {rce, ace, ah}, {2'b10, 4'hF});
        idle();
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic rce, ace;
        logic [4:0] rh;
        logic [3:0] ah;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1, R2: reset map
        check_map(8'h00, 8'h00, "R1/R2");

        // R9: no request, and an I/O cycle, assert no enable
        @(negedge clk); idle(); cpu_addr = 16'h0100; #2;
        check(rom_ce_n && ram_ce_n, "R9 idle", {rom_ce_n, ram_ce_n}, 2'b11);
        @(negedge clk); iorq_n = 1'b0; rd_n = 1'b0; #2;
        check(rom_ce_n && ram_ce_n, "R9 io", {rom_ce_n, ram_ce_n}, 2'b11);
        idle();

        // R3: every ROM page
        for (int p = 0; p < 32; p++) begin
            bus_write(16'h007C, 8'(p), 1'b1, 1'b0);
            check_map(8'(p), 8'h00, "R3");
        end

        // R4, R5: every SRAM page with ROM switched out
        for (int g = 0; g < 16; g++) begin
            bus_write(16'h0078, 8'(g), 1'b1, 1'b0);
            bus_write(16'h007C, 8'h80 | 8'(g[3:0] ^ 4'h5), 1'b1, 1'b0);
            check_map(8'h80 | 8'(g[3:0] ^ 4'h5), 8'(g), "R4/R5");
        end
        // R10: page 15 in lower window equals upper page
        probe(16'h0042, 1'b0, rce, ace, rh, ah);
        check(ah == 4'hF && !ace, "R10", ah, 4'hF);
        idle();

        // R5: clearing bit 7 brings ROM back
        bus_write(16'h007C, 8'h03, 1'b1, 1'b0);
        bus_write(16'h0078, 8'h06, 1'b1, 1'b0);
        check_map(8'h03, 8'h06, "R5 back");

        // R7: other low bytes ignored; high byte of port ignored
        bus_write(16'h0079, 8'h9F, 1'b1, 1'b0);
        bus_write(16'h007D, 8'h9F, 1'b1, 1'b0);
        bus_write(16'h00FC, 8'h9F, 1'b1, 1'b0);
        bus_write(16'h00F8, 8'h9F, 1'b1, 1'b0);
        check_map(8'h03, 8'h06, "R7 other ports");
        bus_write(16'hAB7C, 8'h8A, 1'b1, 1'b0);
        bus_write(16'h5578, 8'h0C, 1'b1, 1'b0);
        check_map(8'h8A, 8'h0C, "R7 high byte");

        // R8: M1 cycle, I/O read, memory write leave registers alone
        bus_write(16'h007C, 8'h11, 1'b1, 1'b1);
        bus_write(16'h0078, 8'h01, 1'b1, 1'b1);
        io_read(16'h007C);
        io_read(16'h0078);
        bus_write(16'h007C, 8'h12, 1'b0, 1'b0);
        bus_write(16'h0078, 8'h02, 1'b0, 1'b0);
        check_map(8'h8A, 8'h0C, "R8");

        // R1: reset clears a loaded state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_map(8'h00, 8'h00, "R1 re-reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule